// File: doc/BRIEF.md
# Accumulator ALU with mode-selected destination

This block is the byte-wide arithmetic and logic stage of a small accumulator machine. Each request carries an operation code, the accumulator, a memory operand, the byte currently stored at the location pointed to by index register X, the incoming carry and overflow flags, and a mode bit. One clock later the block presents a result byte, a write strobe, a destination select, and new negative, overflow, zero and carry flags.

The mode bit changes where add and AND take their first operand from, and where their results go. With the mode bit clear, the accumulator is both source and destination. With it set, the byte at X is the first operand and the result is written back to that byte. Shift left follows the same rule. Bit test always combines the accumulator with the memory operand, writes nothing, and changes only the flags.

All logic before the output register is combinational. The output stage is a single register, and it loads only on a request cycle.

Top module: `acc_alu`

## Requirements
- R1: While reset is held (active low) and on the first cycle after it, `out_valid`, `res`, `res_we`, `dst_mem` and all four flag outputs are 0.
- R2: `out_valid` is high exactly one clock after a cycle with `req_valid` high, and low otherwise. The outputs are updated only for a request and keep their values on idle cycles.
- R3: Add (`op`=0) with `tmode`=0 gives `res` = (`acc` + `mem` + `c_in`) mod 256, with `dst_mem`=0 and `res_we`=1.
- R4: Add with `tmode`=1 gives `res` = (`mem_x` + `mem` + `c_in`) mod 256, with `dst_mem`=1 and `res_we`=1.
- R5: Add sets C to the carry out of bit 7. It sets V when the two operands have the same sign bit and the result's sign bit differs. N is `res` bit 7, and Z is set when `res` is 0.
- R6: AND (`op`=1) gives `res` = first operand AND `mem`, where the first operand is `acc` when `tmode`=0 and `mem_x` when `tmode`=1. `dst_mem` equals `tmode` and `res_we`=1. C and V pass through from `c_in` and `v_in`. N and Z follow `res`.
- R7: Shift left (`op`=2) shifts the first operand (`acc` when `tmode`=0, `mem_x` when `tmode`=1) left by one and clears bit 0. C takes the old bit 7, and V passes through from `v_in`. N and Z follow `res`. `dst_mem` equals `tmode` and `res_we`=1.
- R8: Bit test (`op`=3) sets `res_we`=0 and `dst_mem`=0, with `res` = `acc` AND `mem`, whatever the value of `tmode`. N is `mem` bit 7, V is `mem` bit 6, Z is set when `acc` AND `mem` is 0, and C passes through from `c_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| op | input | 2 | 0 add, 1 AND, 2 shift left, 3 bit test |
| tmode | input | 1 | Selects the byte at X as first operand and destination |
| acc | input | 8 | Accumulator value |
| mem | input | 8 | Memory operand |
| mem_x | input | 8 | Byte at the address held in X |
| c_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result strobe, one clock after a request |
| res | output | 8 | Result byte |
| res_we | output | 1 | Result is to be stored |
| dst_mem | output | 1 | 0 accumulator, 1 memory at X |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every result is due exactly one clock after the request that produced it. A request that is driven at a falling edge is captured at the next rising edge and checked at the falling edge that follows. The bench's reference model keeps a one-entry queue of expected outputs. At each falling edge it compares the queue entry against all outputs, and only then drives the next stimulus. On idle cycles the queued entry is the previous outputs with the valid flag low, so the hold behaviour is checked on the same schedule.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [1:0]   op,
  input  logic         tmode,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  input  logic [W-1:0] mem_x,
  input  logic         c_in,
  input  logic         v_in,
  output logic         out_valid,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic         dst_mem,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_c
);
  localparam int MSB = W - 1;

  logic [W-1:0] src, r;
  logic [W:0]   sum;
  logic         n, v, c, we, dm;

  assign src = tmode ? mem_x : acc;
  assign sum = {1'b0, src} + {1'b0, mem} + {{W{1'b0}}, c_in};

  always_comb begin
    r  = '0;
    c  = c_in;
    v  = v_in;
    we = 1'b1;
    dm = tmode;
    unique case (op)
      2'd0: begin
        r = sum[W-1:0];
        c = sum[W];
        v = (src[MSB] == mem[MSB]) && (r[MSB] != src[MSB]);
      end
      2'd1: r = src & mem;
      2'd2: begin
        r = {src[W-2:0], 1'b0};
        c = src[MSB];
      end
      default: begin
        r  = acc & mem;
        v  = mem[MSB-1];
        we = 1'b0;
        dm = 1'b0;
      end
    endcase
    n = (op == 2'd3) ? mem[MSB] : r[MSB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      res_we    <= 1'b0;
      dst_mem   <= 1'b0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        res     <= r;
        res_we  <= we;
        dst_mem <= dm;
        flag_n  <= n;
        flag_v  <= v;
        flag_z  <= (r == '0);
        flag_c  <= c;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(res) && $stable(flag_c)));
  // R8
  bit_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == 2'd3) |=> (!res_we && flag_n == $past(mem[MSB]) && flag_v == $past(mem[MSB-1])));
  // R7
  shift_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == 2'd2) |=> (!res[0] && flag_c == $past(src[MSB])));
  // R6
  and_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == 2'd1) |=> (flag_c == $past(c_in) && flag_v == $past(v_in)));
  // R4
  dest_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op != 2'd3) |=> (dst_mem == $past(tmode) && res_we));
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, req_valid = 0, tmode = 0, c_in = 0, v_in = 0;
  logic [1:0] op = 0;
  logic [7:0] acc = 0, mem = 0, mem_x = 0;
  logic out_valid, res_we, dst_mem, flag_n, flag_v, flag_z, flag_c;
  logic [7:0] res;

  int checks = 0, fails = 0;
  int e_valid, e_res, e_we, e_dm, e_n, e_v, e_z, e_c;

  acc_alu dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic string tag(input int o, input int t);
    case (o)
      0: return t ? "R4/R5" : "R3/R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(input string r, input string nm, input int a, input int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, nm, a, e);
    end
  endtask

  task automatic check_all(input string r);
    cmp("R2", "out_valid", out_valid, e_valid);
    cmp(r, "res", res, e_res);
    cmp(r, "res_we", res_we, e_we);
    cmp(r, "dst_mem", dst_mem, e_dm);
    cmp(r, "flag_n", flag_n, e_n);
    cmp(r, "flag_v", flag_v, e_v);
    cmp(r, "flag_z", flag_z, e_z);
    cmp(r, "flag_c", flag_c, e_c);
  endtask

  task automatic model(input bit rq, input int o, input int t, input int a,
                       input int m, input int mx, input int ci, input int vi);
    int f, s;
    e_valid = rq;
    if (!rq) return;
    f = t ? mx : a;
    e_c = ci; e_v = vi; e_we = 1; e_dm = t;
    case (o)
      0: begin
        s = f + m + ci;
        e_res = s % 256;
        e_c = (s > 255);
        e_v = (((f ^ e_res) & (m ^ e_res) & 128) != 0);
      end
      1: e_res = f & m;
      2: begin e_res = (f * 2) % 256; e_c = (f >= 128); end
      default: begin
        e_res = a & m; e_we = 0; e_dm = 0; e_v = (m / 64) % 2;
      end
    endcase
    e_n = (o == 3) ? (m / 128) : (e_res / 128);
    e_z = (e_res == 0);
  endtask

  string last_tag = "R2";

  task automatic step(input bit rq, input int o, input int t, input int a,
                      input int m, input int mx, input int ci, input int vi);
    req_valid = rq; op = o[1:0]; tmode = t[0]; acc = a[7:0]; mem = m[7:0];
    mem_x = mx[7:0]; c_in = ci[0]; v_in = vi[0];
    model(rq, o, t, a, m, mx, ci, vi);
    if (rq) last_tag = tag(o, t); else last_tag = {last_tag, "/R2"};
    @(negedge clk);
    check_all(last_tag);
  endtask

  initial begin
    e_valid = 0; e_res = 0; e_we = 0; e_dm = 0; e_n = 0; e_v = 0; e_z = 0; e_c = 0;
    req_valid = 1;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1; req_valid = 0;
    @(negedge clk);
    check_all("R1");
    // R3 R5: carry out and overflow corners
    step(1, 0, 0, 8'h7F, 8'h01, 8'h00, 0, 0);
    step(1, 0, 0, 8'hFF, 8'h00, 8'h00, 1, 0);
    step(1, 0, 0, 8'h80, 8'h80, 8'h11, 0, 0);
    // R4: memory at X as source
    step(1, 0, 1, 8'h00, 8'h10, 8'h25, 1, 0);
    // R6
    step(1, 1, 0, 8'hF0, 8'h3C, 8'h00, 1, 1);
    step(1, 1, 1, 8'hFF, 8'h0F, 8'hF0, 0, 1);
    // R7
    step(1, 2, 0, 8'h81, 8'h00, 8'h00, 0, 1);
    step(1, 2, 1, 8'h00, 8'h00, 8'h40, 1, 0);
    // R8: tmode ignored, flags from mem
    step(1, 3, 1, 8'h0F, 8'hC0, 8'hFF, 1, 0);
    step(1, 3, 0, 8'hFF, 8'h41, 8'h00, 0, 1);
    // R2: idle holds
    step(0, 0, 0, 8'h55, 8'h55, 8'h55, 1, 1);
    step(0, 2, 1, 8'hAA, 8'h01, 8'h80, 0, 0);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 2, $urandom % 256,
           $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule